// File: doc/BRIEF.md
# Hot-Swap Current Limit Mode Controller

This block is the control logic behind a hot-swap pass switch on a powered line. It watches a set of synchronous comparator flags: the line voltage against turn-on and turn-off thresholds, the drain-source voltage of the pass switch against low and high power-good levels, the gate-fully-on status, and an over-temperature flag. From these it decides three things. It decides whether the switch conducts. It decides whether the switch works under the low inrush current limit or the higher operational limit. It decides whether the downstream converter may run.

A filtered lockout stage debounces the line flags so that short cable dips do not cause a power cycle. Behind it sits a four-state machine:

- `ST_OFF`: line locked out.
- `ST_INRUSH`: switch on, inrush limit.
- `ST_OPER`: switch on, operational limit, converter running.
- `ST_THERMAL`: shut down by over-temperature.

Transitions:

- `ST_OFF`→`ST_INRUSH` when the filtered line is good and the part is cool.
- `ST_OFF`→`ST_THERMAL` when the filtered line is good and the part is hot.
- `ST_INRUSH`→`ST_OPER` when the drain-source voltage is low and the gate is fully on in the same cycle.
- `ST_OPER`→`ST_INRUSH` when the drain-source voltage is high.
- `ST_INRUSH`/`ST_OPER`→`ST_THERMAL` on over-temperature.
- `ST_THERMAL`→`ST_INRUSH` when the temperature flag clears.
- Any state→`ST_OFF` when the filtered line drops.

Top module: `hs_limit_ctrl`

## Requirements
- R1: While reset is held and right after it, `pass_en`, `reg_en` and `conv_en` are 0, `sel_oper` is 0 (0 selects the inrush limit, 1 the operational limit) and `ss_discharge` is 1.
- R2: Once `line_above_on` has been 1 for FILT_CYCLES consecutive cycles, `reg_en` rises at the clock edge that ends the last of those cycles. `pass_en` rises one edge later, with `sel_oper` still 0.
- R3: A run of `line_above_on` shorter than FILT_CYCLES leaves `reg_en` and `pass_en` at 0. Any cycle with the flag at 0 restarts the count.
- R4: `sel_oper` rises only at the edge after a cycle in which `vds_low` and `gate_full` were both 1. Either flag alone does not change the limit.
- R5: While the operational limit is selected, it stays selected until `vds_high` is 1 at a clock edge. That edge returns `sel_oper` to 0 and drops `conv_en`.
- R6: `conv_en` is 1 only while the operational limit is selected and the switch is on. `ss_discharge` is the inverse of `conv_en`.
- R7: In any cycle with `over_temp` at 1, `pass_en`, `reg_en` and `conv_en` are 0 without waiting for a clock edge. From the next edge the operational limit is deselected.
- R8: When `over_temp` returns to 0 with the line still good, the switch restarts under the inrush limit with `ss_discharge` at 1. The converter stays off until the condition of R4 is met again.
- R9: Once `line_below_off` has been 1 for FILT_CYCLES consecutive cycles, the outputs return to the R1 values. A shorter run of `line_below_off` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_above_on | input | 1 | Line is above the turn-on threshold |
| line_below_off | input | 1 | Line is below the turn-off threshold |
| vds_low | input | 1 | Switch drain-source voltage is below the low power-good level |
| vds_high | input | 1 | Switch drain-source voltage is above the high power-good level |
| gate_full | input | 1 | Switch gate is fully enhanced (not limiting) |
| over_temp | input | 1 | Junction over-temperature |
| sel_oper | output | 1 | 1 selects the operational limit, 0 the inrush limit |
| pass_en | output | 1 | Pass switch enable |
| reg_en | output | 1 | Internal regulator enable |
| conv_en | output | 1 | Downstream converter enable |
| ss_discharge | output | 1 | Soft-start capacitor discharge |

## Verification
The assertions assume that every input flag is synchronous to `clk`. They also assume that `vds_low` and `vds_high` are never both 1, and that `line_above_on` and `line_below_off` are never both 1, as real comparators on one voltage would guarantee. The stimulus changes inputs only on the falling clock edge. It never raises both flags of either pair in the same cycle. It builds runs of line flags both just under and exactly at the filter length, so the lockout boundary is exercised in both directions.

// File: rtl/hs_limit_pkg.sv
package hs_limit_pkg;
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_INRUSH  = 2'd1,
        ST_OPER    = 2'd2,
        ST_THERMAL = 2'd3
    } hs_state_t;
endpackage

// File: rtl/hs_lockout_filter.sv
module hs_lockout_filter #(
    parameter int FILT_CYCLES = 90
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_on,
    input  logic below_off,
    output logic line_ok
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(FILT_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          wants_flip;

    // The raw flag that argues against the present lockout decision
    assign wants_flip = line_ok ? below_off : above_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= RELOAD;
            line_ok <= 1'b0;
        end else if (!wants_flip) begin
            cnt_q <= RELOAD;
        end else if (cnt_q == '0) begin
            cnt_q   <= RELOAD;
            line_ok <= ~line_ok;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/hs_mode_fsm.sv
module hs_mode_fsm
    import hs_limit_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      line_ok,
    input  logic      vds_low,
    input  logic      vds_high,
    input  logic      gate_full,
    input  logic      over_temp,
    output hs_state_t state
);
    hs_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (line_ok) nxt = over_temp ? ST_THERMAL : ST_INRUSH;
            end
            ST_INRUSH: begin
                if (!line_ok)                nxt = ST_OFF;
                else if (over_temp)          nxt = ST_THERMAL;
                else if (vds_low && gate_full) nxt = ST_OPER;
            end
            ST_OPER: begin
                if (!line_ok)       nxt = ST_OFF;
                else if (over_temp) nxt = ST_THERMAL;
                else if (vds_high)  nxt = ST_INRUSH;
            end
            ST_THERMAL: begin
                if (!line_ok)        nxt = ST_OFF;
                else if (!over_temp) nxt = ST_INRUSH;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end
endmodule

// File: rtl/hs_out_decode.sv
module hs_out_decode
    import hs_limit_pkg::*;
(
    input  hs_state_t state,
    input  logic      line_ok,
    input  logic      over_temp,
    output logic      sel_oper,
    output logic      pass_en,
    output logic      reg_en,
    output logic      conv_en,
    output logic      ss_discharge
);
    logic live;

    always_comb begin
        live         = line_ok && !over_temp;
        sel_oper     = 1'b0;
        pass_en      = 1'b0;
        conv_en      = 1'b0;
        reg_en       = live;
        unique case (state)
            ST_OFF:     ;
            ST_INRUSH:  pass_en = live;
            ST_OPER: begin
                sel_oper = 1'b1;
                pass_en  = live;
                conv_en  = live;
            end
            ST_THERMAL: ;
        endcase
        ss_discharge = !conv_en;
    end
endmodule

// File: rtl/hs_limit_ctrl.sv
module hs_limit_ctrl
    import hs_limit_pkg::*;
#(
    parameter int FILT_CYCLES = 90
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_above_on,
    input  logic line_below_off,
    input  logic vds_low,
    input  logic vds_high,
    input  logic gate_full,
    input  logic over_temp,
    output logic sel_oper,
    output logic pass_en,
    output logic reg_en,
    output logic conv_en,
    output logic ss_discharge
);
    logic      line_ok;
    hs_state_t state;

    hs_lockout_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .above_on  (line_above_on),
        .below_off (line_below_off),
        .line_ok   (line_ok)
    );

    hs_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_ok   (line_ok),
        .vds_low   (vds_low),
        .vds_high  (vds_high),
        .gate_full (gate_full),
        .over_temp (over_temp),
        .state     (state)
    );

    hs_out_decode u_dec (
        .state        (state),
        .line_ok      (line_ok),
        .over_temp    (over_temp),
        .sel_oper     (sel_oper),
        .pass_en      (pass_en),
        .reg_en       (reg_en),
        .conv_en      (conv_en),
        .ss_discharge (ss_discharge)
    );
endmodule

// File: rtl/hs_limit_ctrl_chk.sv
module hs_limit_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic vds_low,
    input logic vds_high,
    input logic gate_full,
    input logic over_temp,
    input logic sel_oper,
    input logic pass_en,
    input logic reg_en,
    input logic conv_en,
    input logic ss_discharge
);
    AST_CONV_NEEDS_OPER: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en |-> (sel_oper && pass_en)); // R6
    AST_SS_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en != ss_discharge); // R6
    AST_HOT_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp |-> (!pass_en && !reg_en && !conv_en)); // R7
    AST_HOT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp |=> !sel_oper); // R7
    AST_OPER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_oper) |-> $past(vds_low && gate_full)); // R4
    AST_OPER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_oper && vds_high) |=> !sel_oper); // R5
    AST_PASS_NEEDS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        pass_en |-> reg_en); // R2
endmodule

bind hs_limit_ctrl hs_limit_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vds_low      (vds_low),
    .vds_high     (vds_high),
    .gate_full    (gate_full),
    .over_temp    (over_temp),
    .sel_oper     (sel_oper),
    .pass_en      (pass_en),
    .reg_en       (reg_en),
    .conv_en      (conv_en),
    .ss_discharge (ss_discharge)
);

// File: tb/tb_hs_limit_ctrl.sv
module tb_hs_limit_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int FILT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above_on = 0, below_off = 0, vlo = 0, vhi = 0, gfull = 0, hot = 0;
    logic sel_oper, pass_en, reg_en, conv_en, ss_dis;

    int compared = 0;
    int mismatched = 0;

    // reference model state: 0 off, 1 inrush, 2 operational, 3 thermal
    int m_st = 0;
    int m_run = 0;
    bit m_ok = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs_limit_ctrl #(.FILT_CYCLES(FILT)) dut (
        .clk(clk), .rst_n(rst_n),
        .line_above_on(above_on), .line_below_off(below_off),
        .vds_low(vlo), .vds_high(vhi), .gate_full(gfull), .over_temp(hot),
        .sel_oper(sel_oper), .pass_en(pass_en), .reg_en(reg_en),
        .conv_en(conv_en), .ss_discharge(ss_dis)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_run = 0; m_ok = 0;
        end else begin
            int nst;
            nst = m_st;
            if (!m_ok) nst = (m_st == 0) ? 0 : 0;
            if (m_ok) begin
                if (m_st == 0)      nst = hot ? 3 : 1;
                else if (hot)       nst = 3;
                else if (m_st == 3) nst = 1;
                else if (m_st == 1 && vlo && gfull) nst = 2;
                else if (m_st == 2 && vhi) nst = 1;
            end
            m_st = nst;
            if (m_ok ? below_off : above_on) m_run++;
            else m_run = 0;
            if (m_run == FILT) begin
                m_ok = !m_ok;
                m_run = 0;
            end
        end
    end

    task automatic chk(string tag, string what, logic got, logic exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic cmp_all();
        bit live;
        live = m_ok && !hot;
        chk("R2", "reg_en", reg_en, live);
        chk("R2", "pass_en", pass_en, live && (m_st == 1 || m_st == 2));
        chk("R4", "sel_oper", sel_oper, m_st == 2);
        chk("R6", "conv_en", conv_en, live && m_st == 2);
        chk("R8", "ss_discharge", ss_dis, !(live && m_st == 2));
    endtask

    // advance n cycles, compare after each falling edge
    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1 cmp_all();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        mismatched++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3 + 2);
        chk("R1", "pass_en in reset", pass_en, 1'b0);
        chk("R1", "ss_discharge in reset", ss_dis, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        run(2);
        chk("R1", "sel_oper after reset", sel_oper, 1'b0);
        chk("R1", "conv_en after reset", conv_en, 1'b0);

        // R3: short runs with a break never turn on
        above_on = 1; run(FILT - 1);
        above_on = 0; run(1);
        above_on = 1; run(FILT - 1);
        chk("R3", "reg_en short run", reg_en, 1'b0);
        chk("R3", "pass_en short run", pass_en, 1'b0);

        // R2: full run turns regulators on, then the switch in inrush
        run(1);
        chk("R2", "reg_en at filter end", reg_en, 1'b1);
        chk("R2", "pass_en one edge before", pass_en, 1'b0);
        run(1);
        chk("R2", "pass_en", pass_en, 1'b1);
        chk("R2", "inrush selected", sel_oper, 1'b0);
        above_on = 0;

        // R4: one condition alone is not enough
        vlo = 1; run(3);
        vlo = 0; gfull = 1; run(3);
        chk("R4", "gate only", sel_oper, 1'b0);
        vlo = 1; run(1);
        chk("R4", "both set", sel_oper, 1'b1);
        chk("R6", "conv_en in oper", conv_en, 1'b1);
        chk("R6", "ss released", ss_dis, 1'b0);

        // R5: operational limit holds with vds between levels
        vlo = 0; gfull = 0; run(4);
        chk("R5", "held", sel_oper, 1'b1);
        vhi = 1; run(1);
        chk("R5", "vds high exit", sel_oper, 1'b0);
        chk("R5", "conv_en dropped", conv_en, 1'b0);
        vhi = 0; run(2);
        vlo = 1; gfull = 1; run(1);
        chk("R4", "re-enter", sel_oper, 1'b1);

        // R7: over-temperature shuts down in the same cycle
        @(negedge clk); hot = 1; #1;
        chk("R7", "pass_en immediate", pass_en, 1'b0);
        chk("R7", "conv_en immediate", conv_en, 1'b0);
        chk("R7", "reg_en immediate", reg_en, 1'b0);
        cmp_all();
        run(3);
        chk("R7", "deselected", sel_oper, 1'b0);

        // R8: restart in inrush, converter waits
        vlo = 0; gfull = 0;
        hot = 0; run(1);
        chk("R8", "pass_en restart", pass_en, 1'b1);
        chk("R8", "inrush on restart", sel_oper, 1'b0);
        chk("R8", "ss discharging", ss_dis, 1'b1);
        run(3);
        chk("R8", "conv still off", conv_en, 1'b0);
        vlo = 1; gfull = 1; run(1);
        chk("R8", "oper after charge", conv_en, 1'b1);
        vlo = 0; gfull = 0;

        // R9: short dip ignored, long dip locks out
        below_off = 1; run(FILT - 1);
        below_off = 0; run(1);
        chk("R9", "dip ignored", conv_en, 1'b1);
        below_off = 1; run(FILT);
        chk("R9", "reg_en off", reg_en, 1'b0);
        chk("R9", "pass_en off", pass_en, 1'b0);
        run(1);
        chk("R9", "sel back to inrush", sel_oper, 1'b0);
        chk("R9", "ss discharge", ss_dis, 1'b1);
        below_off = 0; run(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule